// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a register-mapped general-purpose I/O controller. Its pins are grouped in banks of 32, and each bank has its own window in the address space. Software reaches the registers over a single-cycle 32-bit access port: an address, a write strobe, write data, and read data that follows the address combinationally. For every pin the block drives an output value, an output enable, a pull enable, a pull direction and a 3-bit drive-strength code. It also samples the pad input through a two-stage synchronizer.

Each pin can raise an interrupt. The trigger is set per pin to one of three kinds: a level of selectable polarity, a single edge of selectable direction, or both edges. A triggered pin latches a raw status bit. An enable mask chooses which latched bits reach the one interrupt line. A software clear port drops latched bits one pin at a time. When a new event arrives in the same cycle as a clear, the event wins.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every writable register reads zero. The outputs pad_out, pad_oe, pull_en, pull_up, drive_code and irq are all zero.
- R2: Bank n occupies byte addresses n*0x200 to n*0x200+0x1FF. Pin p is bank p/32, bit p mod 32. An access with address bits [1:0] not zero is ignored and reads zero. An offset with no register reads zero.
- R3: The input word at offset 0x00 shows the pad inputs after two clock edges of synchronization. Writes to it have no effect.
- R4: The word at offset 0x04 drives pad_out and the word at offset 0x08 drives pad_oe (1 means driven). Both read back what was written, and they hold their value while no write occurs.
- R5: The word at 0x34 selects the pull direction on pull_up (1 means up, 0 means down). The word at 0x38 drives pull_en (1 means pull on).
- R6: Bit p of the words at 0x58, 0x5C and 0x60 gives bits 0, 1 and 2 of the drive code for pin p. The code appears on drive_code[3p+2:3p] and stands for (code+1)*2 mA.
- R7: With the type bit (0x0C) at 0 and the both-edge bit (0x10) at 0, the polarity bit (0x14) selects the trigger: 1 means a rising edge and 0 means a falling edge. The raw status at 0x1C reads 1 three clock edges after the pad changes.
- R8: With the type bit at 0 and the both-edge bit at 1, either edge sets the raw status, whatever the polarity bit holds.
- R9: With the type bit at 1, the pin triggers on its level: high when polarity is 1, low when polarity is 0. While the active level is present, the status stays set even across a clear.
- R10: The word at 0x20 reads raw status AND the mask at 0x18. irq is high exactly when any bit of this masked word is set in any bank.
- R11: Writing a 1 to a bit at 0x24 clears that pin's raw status, and a 0 bit leaves it unchanged. The word reads zero. A new event in the cycle of the clear keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| pad_in | input | NUM_BANKS*32 | Asynchronous pad inputs |
| pad_out | output | NUM_BANKS*32 | Pad output values |
| pad_oe | output | NUM_BANKS*32 | Pad output enables |
| pull_en | output | NUM_BANKS*32 | Pull resistor enables |
| pull_up | output | NUM_BANKS*32 | Pull direction, 1 means up |
| drive_code | output | NUM_BANKS*96 | 3-bit drive code per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clear write that lands on the same clock edge as a fresh trigger. The bench times it by counting edges from the pad change: the write strobe rises after the second edge, so the clear is taken on the third, which is the edge where the status latches. A second hard case is a level trigger that must stay set across a clear. To cover it, the bench sweeps all eight settings of the type, both-edge and polarity bits. For each setting it drives one pin through a rise, a fall and clears, using pins in both banks. The expected raw, masked and interrupt values are derived from the mode bits.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PINS_PER_BANK = 32;
    localparam int BANK_LSB      = 9;
    localparam int WSEL_W        = 7;
    localparam int DRV_BITS      = 3;

    // word indices inside a bank window (byte offset / 4)
    localparam logic [WSEL_W-1:0] W_PADIN = 7'd0;
    localparam logic [WSEL_W-1:0] W_OUTV  = 7'd1;
    localparam logic [WSEL_W-1:0] W_DRVEN = 7'd2;
    localparam logic [WSEL_W-1:0] W_LEVEL = 7'd3;
    localparam logic [WSEL_W-1:0] W_BOTH  = 7'd4;
    localparam logic [WSEL_W-1:0] W_POLAR = 7'd5;
    localparam logic [WSEL_W-1:0] W_ENMSK = 7'd6;
    localparam logic [WSEL_W-1:0] W_RAW   = 7'd7;
    localparam logic [WSEL_W-1:0] W_MSKD  = 7'd8;
    localparam logic [WSEL_W-1:0] W_ACK   = 7'd9;
    localparam logic [WSEL_W-1:0] W_PDIR  = 7'd13;
    localparam logic [WSEL_W-1:0] W_PON   = 7'd14;
    localparam logic [WSEL_W-1:0] W_STR0  = 7'd22;

    typedef struct packed {
        logic [PINS_PER_BANK-1:0]               outv;
        logic [PINS_PER_BANK-1:0]               drven;
        logic [PINS_PER_BANK-1:0]               level;
        logic [PINS_PER_BANK-1:0]               both;
        logic [PINS_PER_BANK-1:0]               polar;
        logic [PINS_PER_BANK-1:0]               enmsk;
        logic [PINS_PER_BANK-1:0]               raw;
        logic [PINS_PER_BANK-1:0]               pdir;
        logic [PINS_PER_BANK-1:0]               pon;
        logic [DRV_BITS-1:0][PINS_PER_BANK-1:0] str;
        logic [PINS_PER_BANK-1:0]               last;
    } bank_state_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_d, stage1_q;
    logic [WIDTH-1:0] stage2_d, stage2_q;

    always_comb begin
        stage1_d = async_in;
        stage2_d = stage1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= stage1_d;
            stage2_q <= stage2_d;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] now_v,
    input  logic [WIDTH-1:0] last_v,
    input  logic [WIDTH-1:0] level_sel,
    input  logic [WIDTH-1:0] both_sel,
    input  logic [WIDTH-1:0] polar_sel,
    output logic [WIDTH-1:0] hit
);
    logic [WIDTH-1:0] rise, fall, lvl_hit, edge_hit;

    always_comb begin
        rise     = now_v & ~last_v;
        fall     = ~now_v & last_v;
        lvl_hit  = (polar_sel & now_v) | (~polar_sel & ~now_v);
        edge_hit = (both_sel & (rise | fall))
                 | (~both_sel & ((polar_sel & rise) | (~polar_sel & fall)));
        hit      = (level_sel & lvl_hit) | (~level_sel & edge_hit);
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [WSEL_W-1:0]        wsel,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata,
    input  logic [PINS_PER_BANK-1:0] pins_sync,
    output logic [PINS_PER_BANK-1:0] outv,
    output logic [PINS_PER_BANK-1:0] drven,
    output logic [PINS_PER_BANK-1:0] pdir,
    output logic [PINS_PER_BANK-1:0] pon,
    output logic [DRV_BITS-1:0][PINS_PER_BANK-1:0] str,
    output logic [PINS_PER_BANK-1:0] raw,
    output logic [PINS_PER_BANK-1:0] enmsk,
    output logic [PINS_PER_BANK-1:0] evt
);
    bank_state_t st_d, st_q;
    logic [PINS_PER_BANK-1:0] ack;

    gpio_evt_detect #(.WIDTH(PINS_PER_BANK)) u_detect (
        .now_v     (pins_sync),
        .last_v    (st_q.last),
        .level_sel (st_q.level),
        .both_sel  (st_q.both),
        .polar_sel (st_q.polar),
        .hit       (evt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.last = pins_sync;
        ack       = '0;
        if (wr_en) begin
            case (wsel)
                W_OUTV:  st_d.outv  = wdata;
                W_DRVEN: st_d.drven = wdata;
                W_LEVEL: st_d.level = wdata;
                W_BOTH:  st_d.both  = wdata;
                W_POLAR: st_d.polar = wdata;
                W_ENMSK: st_d.enmsk = wdata;
                W_ACK:   ack        = wdata;
                W_PDIR:  st_d.pdir  = wdata;
                W_PON:   st_d.pon   = wdata;
                default: ;
            endcase
            for (int i = 0; i < DRV_BITS; i++) begin
                if (wsel == W_STR0 + WSEL_W'(i)) st_d.str[i] = wdata;
            end
        end
        // a fresh event outranks a same-cycle acknowledge
        st_d.raw = (st_q.raw & ~ack) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (wsel)
            W_PADIN: rdata = pins_sync;
            W_OUTV:  rdata = st_q.outv;
            W_DRVEN: rdata = st_q.drven;
            W_LEVEL: rdata = st_q.level;
            W_BOTH:  rdata = st_q.both;
            W_POLAR: rdata = st_q.polar;
            W_ENMSK: rdata = st_q.enmsk;
            W_RAW:   rdata = st_q.raw;
            W_MSKD:  rdata = st_q.raw & st_q.enmsk;
            W_PDIR:  rdata = st_q.pdir;
            W_PON:   rdata = st_q.pon;
            default: rdata = '0;
        endcase
        for (int i = 0; i < DRV_BITS; i++) begin
            if (wsel == W_STR0 + WSEL_W'(i)) rdata = st_q.str[i];
        end
    end

    assign outv  = st_q.outv;
    assign drven = st_q.drven;
    assign pdir  = st_q.pdir;
    assign pon   = st_q.pon;
    assign str   = st_q.str;
    assign raw   = st_q.raw;
    assign enmsk = st_q.enmsk;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = BANK_LSB + ((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic [NUM_BANKS*32-1:0]     pad_in,
    output logic [NUM_BANKS*32-1:0]     pad_out,
    output logic [NUM_BANKS*32-1:0]     pad_oe,
    output logic [NUM_BANKS*32-1:0]     pull_en,
    output logic [NUM_BANKS*32-1:0]     pull_up,
    output logic [NUM_BANKS*96-1:0]     drive_code,
    output logic                        irq
);
    localparam int NPINS  = NUM_BANKS * PINS_PER_BANK;
    localparam int BSEL_W = ADDR_W - BANK_LSB;

    logic [NPINS-1:0]   pins_sync;
    logic [NPINS-1:0]   stat_all, mask_all, event_all;
    logic [DRV_BITS-1:0][NPINS-1:0] str_all;
    logic [NUM_BANKS-1:0][31:0]     bank_rd;
    logic [BSEL_W-1:0]  bank_idx;
    logic [WSEL_W-1:0]  wsel;
    logic               aligned;

    assign bank_idx = bus_addr[ADDR_W-1:BANK_LSB];
    assign wsel     = bus_addr[BANK_LSB-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);

    gpio_sync #(.WIDTH(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pins_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO = b * PINS_PER_BANK;
        logic [DRV_BITS-1:0][PINS_PER_BANK-1:0] bank_str;

        gpio_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (bus_we && aligned && (bank_idx == BSEL_W'(b))),
            .wsel      (wsel),
            .wdata     (bus_wdata),
            .rdata     (bank_rd[b]),
            .pins_sync (pins_sync[LO +: PINS_PER_BANK]),
            .outv      (pad_out[LO +: PINS_PER_BANK]),
            .drven     (pad_oe[LO +: PINS_PER_BANK]),
            .pdir      (pull_up[LO +: PINS_PER_BANK]),
            .pon       (pull_en[LO +: PINS_PER_BANK]),
            .str       (bank_str),
            .raw       (stat_all[LO +: PINS_PER_BANK]),
            .enmsk     (mask_all[LO +: PINS_PER_BANK]),
            .evt       (event_all[LO +: PINS_PER_BANK])
        );

        for (genvar k = 0; k < DRV_BITS; k++) begin : g_plane
            assign str_all[k][LO +: PINS_PER_BANK] = bank_str[k];
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        for (genvar k = 0; k < DRV_BITS; k++) begin : g_bit
            assign drive_code[DRV_BITS*p + k] = str_all[k][p];
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (aligned && bank_idx == BSEL_W'(b)) bus_rdata = bank_rd[b];
        end
    end

    assign irq = |(stat_all & mask_all);
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic                    bus_we,
    input logic [31:0]             bus_wdata,
    input logic [NUM_BANKS*32-1:0] pad_oe,
    input logic [NUM_BANKS*96-1:0] drive_code,
    input logic                    irq,
    input logic [NUM_BANKS*32-1:0] stat_all,
    input logic [NUM_BANKS*32-1:0] mask_all,
    input logic [NUM_BANKS*32-1:0] event_all
);
    localparam logic [ADDR_W-1:0] A_ACK0  = ADDR_W'(12'h024);
    localparam logic [ADDR_W-1:0] A_STR00 = ADDR_W'(12'h058);

    logic [31:0] plane0;
    always_comb begin
        for (int p = 0; p < 32; p++) plane0[p] = drive_code[3*p];
    end

    // R4
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pad_oe));

    // R7
    event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (event_all != '0) |=> ((stat_all & $past(event_all)) == $past(event_all)));

    // R11
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_all == stat_all) |=> ((stat_all & ~$past(stat_all) & ~$past(event_all)) == '0));

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_all == '0) |-> !irq);

    // R6
    drv_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_STR00) |=> (plane0 == $past(bus_wdata)));

    // R11
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_ACK0 && bus_wdata[0] && !event_all[0]) |=> !stat_all[0]);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .pad_oe     (pad_oe),
    .drive_code (drive_code),
    .irq        (irq),
    .stat_all   (stat_all),
    .mask_all   (mask_all),
    .event_all  (event_all)
);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
    localparam int NB = 2;
    localparam int AW = 10;
    localparam int NP = NB * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, pull_en, pull_up;
    logic [3*NP-1:0] drive_code;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) u_gpio_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en), .pull_up(pull_up),
        .drive_code(drive_code), .irq(irq)
    );

    function automatic logic [AW-1:0] adr(input int bank, input int off);
        return AW'(bank * 'h200 + off);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] pat(input int bank, input int k);
        return 32'h9E37_79B9 * (bank * 13 + k + 1) ^ 32'h5A5A_0F0F;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int offs[15] = '{'h00,'h04,'h08,'h0C,'h10,'h14,'h18,'h1C,'h20,'h24,'h34,'h38,'h58,'h5C,'h60};

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < 15; i++) begin
                rd(adr(b, offs[i]), v);
                chk("R1 reg zero", v, 32'h0);
            end
        chk("R1 pad_out", 32'(|pad_out), 0);
        chk("R1 pad_oe", 32'(|pad_oe), 0);
        chk("R1 pulls", 32'(|{pull_en, pull_up}), 0);
        chk("R1 drive", 32'(|drive_code), 0);
        chk("R1 irq", 32'(irq), 0);

        // R4 R5 R6 register sweep with readback and pin outputs
        for (int b = 0; b < NB; b++) begin
            wr(adr(b, 'h04), pat(b, 0));
            wr(adr(b, 'h08), pat(b, 1));
            wr(adr(b, 'h34), pat(b, 2));
            wr(adr(b, 'h38), pat(b, 3));
            wr(adr(b, 'h58), pat(b, 4));
            wr(adr(b, 'h5C), pat(b, 5));
            wr(adr(b, 'h60), pat(b, 6));
        end
        idle(3);
        for (int b = 0; b < NB; b++) begin
            rd(adr(b, 'h04), v); chk("R4 out readback", v, pat(b, 0));
            chk("R4 pad_out", pad_out[b*32 +: 32], pat(b, 0));
            rd(adr(b, 'h08), v); chk("R4 oe readback", v, pat(b, 1));
            chk("R4 pad_oe", pad_oe[b*32 +: 32], pat(b, 1));
            rd(adr(b, 'h34), v); chk("R5 pull dir readback", v, pat(b, 2));
            chk("R5 pull_up", pull_up[b*32 +: 32], pat(b, 2));
            rd(adr(b, 'h38), v); chk("R5 pull en readback", v, pat(b, 3));
            chk("R5 pull_en", pull_en[b*32 +: 32], pat(b, 3));
            rd(adr(b, 'h5C), v); chk("R6 plane1 readback", v, pat(b, 5));
            for (int p = 0; p < 32; p++) begin
                logic [2:0] code;
                code = {pat(b, 6)[p], pat(b, 5)[p], pat(b, 4)[p]};
                chk("R6 drive code", 32'(drive_code[3*(b*32+p) +: 3]), 32'(code));
            end
        end
        // R6 a pin set for 10 mA carries code 4
        wr(adr(0, 'h58), 32'h0); wr(adr(0, 'h5C), 32'h0); wr(adr(0, 'h60), 32'h0000_0008);
        idle(1);
        chk("R6 10mA code", 32'(drive_code[9 +: 3]), 32'((10 / 2) - 1));

        // R2 misaligned write ignored, reads zero; unmapped offset reads zero
        wr(adr(1, 'h04) | AW'(2), 32'hFFFF_FFFF);
        rd(adr(1, 'h04), v); chk("R2 misaligned write", v, pat(1, 0));
        rd(adr(1, 'h04) | AW'(1), v); chk("R2 misaligned read", v, 32'h0);
        rd(adr(0, 'h2C), v); chk("R2 unmapped", v, 32'h0);
        rd(adr(0, 'h24), v); chk("R11 ack reads zero", v, 32'h0);

        // R3 input sync and read-only
        for (int k = 0; k < 3; k++) begin
            logic [NP-1:0] np, op;
            op = pad_in;
            np = {pat(1, k + 7), pat(0, k + 7)};
            @(negedge clk); pad_in = np;
            @(negedge clk);
            rd(adr(0, 'h00), v); chk("R3 one edge old", v, op[31:0]);
            @(negedge clk);
            rd(adr(0, 'h00), v); chk("R3 two edges bank0", v, np[31:0]);
            rd(adr(1, 'h00), v); chk("R3 two edges bank1", v, np[63:32]);
        end
        wr(adr(0, 'h00), 32'h0);
        rd(adr(0, 'h00), v); chk("R3 write ignored", v, pad_in[31:0]);
        @(negedge clk); pad_in = '0;
        idle(4);

        // R7 R8 R9 R10 R11 mode sweep
        for (int m = 0; m < 8; m++) begin
            logic lvl, dual, pol;
            int pin, bk, bt;
            logic e;
            lvl = m[2]; dual = m[1]; pol = m[0];
            pin = (m * 9 + 3) % NP; bk = pin / 32; bt = pin % 32;
            for (int b = 0; b < NB; b++) begin
                wr(adr(b, 'h0C), {32{lvl}});
                wr(adr(b, 'h10), {32{dual}});
                wr(adr(b, 'h14), {32{pol}});
                wr(adr(b, 'h18), 32'h0);
            end
            idle(4);
            for (int b = 0; b < NB; b++) wr(adr(b, 'h24), 32'hFFFF_FFFF);
            rd(adr(bk, 'h1C), v);
            chk("R9 idle low level", 32'(v[bt]), 32'(lvl & ~pol));

            @(negedge clk); pad_in[pin] = 1'b1;
            idle(4);
            rd(adr(bk, 'h1C), v);
            e = lvl ? 1'b1 : (dual | pol);
            chk(dual && !lvl ? "R8 rise" : (lvl ? "R9 rise" : "R7 rise"), 32'(v[bt]), 32'(e));

            wr(adr(bk, 'h24), 32'(1) << bt);
            rd(adr(bk, 'h1C), v);
            e = lvl & pol;
            chk("R9 clear while high", 32'(v[bt]), 32'(e));

            wr(adr(bk, 'h18), 32'(1) << bt);
            rd(adr(bk, 'h20), v);
            chk("R10 masked high", v, 32'(e) << bt);
            chk("R10 irq high", 32'(irq), 32'(e));

            @(negedge clk); pad_in[pin] = 1'b0;
            idle(4);
            rd(adr(bk, 'h1C), v);
            e = lvl ? 1'b1 : (dual | ~pol);
            chk(dual && !lvl ? "R8 fall" : (lvl ? "R9 fall" : "R7 fall"), 32'(v[bt]), 32'(e));
            chk("R10 irq fall", 32'(irq), 32'(e));

            wr(adr(bk, 'h24), ~(32'(1) << bt));
            rd(adr(bk, 'h1C), v);
            chk("R11 zero bit kept", 32'(v[bt]), 32'(e));

            wr(adr(bk, 'h24), 32'(1) << bt);
            rd(adr(bk, 'h1C), v);
            e = lvl & ~pol;
            chk("R11 clear low", 32'(v[bt]), 32'(e));
            chk("R10 irq after clear", 32'(irq), 32'(e));
        end

        // R11 same-cycle clear and rising event on pin 0
        wr(adr(0, 'h0C), 32'h0); wr(adr(0, 'h10), 32'h0); wr(adr(0, 'h14), 32'hFFFF_FFFF);
        wr(adr(1, 'h0C), 32'h0); wr(adr(1, 'h10), 32'h0);
        idle(4);
        wr(adr(0, 'h24), 32'hFFFF_FFFF);
        @(negedge clk); pad_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = adr(0, 'h24); bus_wdata = 32'h1; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        rd(adr(0, 'h1C), v);
        chk("R11 event wins", 32'(v[0]), 32'h1);
        wr(adr(0, 'h24), 32'h1);
        rd(adr(0, 'h1C), v);
        chk("R11 later clear", 32'(v[0]), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule